// File: doc/BRIEF.md
# Four-Phase Register-File Instruction Sequencer

This block steps a small core through each instruction when the core's whole register file is one single-ported RAM. The RAM can serve only one access per clock, so every instruction is split over four fixed slots. The first slot reads the instruction word at the program counter. The second reads the source register, or takes an immediate value. The third reads the destination register. The fourth writes the result back to the destination, or leaves the port idle. A new instruction therefore starts every fourth clock, whatever it does.

The arithmetic itself is outside the block. The sequencer presents the opcode and both operands on ports. An external combinational function returns a result, and an external decoder raises a jump strobe. There is no stack. A taken jump stores its return address by writing it into the destination register, and it reloads the program counter from the source operand. The RAM is expected to return read data in the same cycle as the address (asynchronous read) and to write on the clock edge that closes the write slot.

The phase machine has four states: `PH_FETCH`, `PH_SRC`, `PH_DST` and `PH_WRITE`. Its transitions are FETCH→SRC, SRC→DST, DST→WRITE and WRITE→FETCH, and it takes one of them on every clock. Reset forces `PH_FETCH`.

Top module: `quad_phase_seq`

## Requirements
- R1: While reset is low and on the first cycle after it is released, `pc` is 0, the phase is fetch, `ram_addr` is 0 and `ram_we` is low.
- R2: The phases repeat as fetch, source, destination, write on consecutive clocks, so each instruction takes exactly four clocks and the RAM sees at most one access per clock.
- R3: The instruction word has these fields: opcode in bits [31:26], write enable in bit 25, immediate flag in bit 24, destination index in bits [17:9] and source index in bits [8:0]. During fetch `ram_addr` equals `pc`. During the source slot it equals the source index. During the destination and write slots it equals the destination index.
- R4: `ram_we` is high only in the write slot, and only when bit 25 of the fetched word is 1. When that bit is 0 the write slot leaves the RAM idle.
- R5: When bit 24 is 1, the source slot is still spent, and `src_val` becomes the 9-bit source index zero-extended in place of the RAM data.
- R6: When `jump_take` is low in the write slot, `ram_wdata` equals `alu_result`.
- R7: When `jump_take` is high in the write slot, `ram_wdata` is `pc`+1 zero-extended (the link value, still gated by bit 25). The next `pc` is the low 9 bits of `src_val`.
- R8: `pc` changes only at the end of the write slot. Without a jump it advances by 1, and it wraps from 511 to 0.
- R9: From the destination slot onward, `op_code`, `src_val` and `dst_val` hold the current instruction's opcode and its two operands for the external function.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ram_addr | output | ADDR_W | Register-file address for the current slot |
| ram_rdata | input | DATA_W | Register-file read data, valid in the same cycle |
| ram_we | output | 1 | Register-file write strobe |
| ram_wdata | output | DATA_W | Register-file write data |
| alu_result | input | DATA_W | Result of the external function of `op_code`, `src_val`, `dst_val` |
| jump_take | input | 1 | Current instruction is a taken jump (sampled in the write slot) |
| op_code | output | 6 | Opcode field of the current instruction |
| src_val | output | DATA_W | Source operand (RAM data or immediate) |
| dst_val | output | DATA_W | Destination operand |
| pc | output | ADDR_W | Program counter |

## Verification
The embedded properties check, on every cycle, several rules. The write strobe appears only in the last slot. The write address matches the address of the destination read just before it. The phase returns to fetch after the write slot. The instruction fields stay frozen outside fetch. An immediate replaces the RAM data. The counter holds, steps or jumps as the jump strobe says. Only the bench's running program can show that whole instructions compute the right values. These cases include the written data and a link value landing in the destination register, a suppressed write leaving a register untouched, instructions skipped by a jump, the counter wrapping at the top of the register space, and a reset in mid-instruction returning to a clean fetch.

// File: rtl/qps_pkg.sv
package qps_pkg;

    // Slot of the four-step instruction cycle
    typedef enum logic [1:0] {
        PH_FETCH = 2'd0,
        PH_SRC   = 2'd1,
        PH_DST   = 2'd2,
        PH_WRITE = 2'd3
    } phase_t;

    // Opcode width, fixed at the top of the instruction word
    localparam int OP_W = 6;

endpackage

// File: rtl/qps_phase_ctrl.sv
module qps_phase_ctrl
    import qps_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    output phase_t phase
);

    phase_t phase_nxt;

    always_comb begin
        unique case (phase)
            PH_FETCH: phase_nxt = PH_SRC;
            PH_SRC:   phase_nxt = PH_DST;
            PH_DST:   phase_nxt = PH_WRITE;
            PH_WRITE: phase_nxt = PH_FETCH;
            default:  phase_nxt = PH_FETCH;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) phase <= PH_FETCH;
        else        phase <= phase_nxt;
    end

    AST_WRITE_THEN_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_WRITE) |=> (phase == PH_FETCH)); // R2

    AST_FETCH_THEN_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_FETCH) |=> (phase == PH_SRC)); // R2

endmodule

// File: rtl/qps_operand_regs.sv
module qps_operand_regs
    import qps_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  phase_t            phase,
    input  logic [DATA_W-1:0] ram_rdata,
    output logic [OP_W-1:0]   op,
    output logic              wr_bit,
    output logic [ADDR_W-1:0] src_idx,
    output logic [ADDR_W-1:0] dst_idx,
    output logic [DATA_W-1:0] src_val,
    output logic [DATA_W-1:0] dst_val
);

    localparam int OP_LO   = DATA_W - OP_W;
    localparam int WE_BIT  = OP_LO - 1;
    localparam int IMM_BIT = OP_LO - 2;
    localparam int GAP_HI  = IMM_BIT - 1;
    localparam int GAP_LO  = 2 * ADDR_W;

    logic imm_flag;
    logic unused_gap;

    assign unused_gap = ^ram_rdata[GAP_HI:GAP_LO];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op       <= '0;
            wr_bit   <= 1'b0;
            imm_flag <= 1'b0;
            src_idx  <= '0;
            dst_idx  <= '0;
            src_val  <= '0;
            dst_val  <= '0;
        end else begin
            unique case (phase)
                PH_FETCH: begin
                    op       <= ram_rdata[DATA_W-1:OP_LO];
                    wr_bit   <= ram_rdata[WE_BIT];
                    imm_flag <= ram_rdata[IMM_BIT];
                    dst_idx  <= ram_rdata[2*ADDR_W-1:ADDR_W];
                    src_idx  <= ram_rdata[ADDR_W-1:0];
                end
                PH_SRC: begin
                    if (imm_flag) src_val <= {{(DATA_W-ADDR_W){1'b0}}, src_idx};
                    else          src_val <= ram_rdata;
                end
                PH_DST:   dst_val <= ram_rdata;
                PH_WRITE: ;
                default:  ;
            endcase
        end
    end

    AST_FIELDS_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != PH_FETCH) |=> ($stable(src_idx) && $stable(dst_idx) && $stable(wr_bit))); // R3

    AST_IMM_OPERAND: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_SRC && imm_flag) |=> (src_val[ADDR_W-1:0] == $past(src_idx)
                                           && src_val[DATA_W-1:ADDR_W] == '0)); // R5

    AST_OPERANDS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_WRITE) |=> ($stable(src_val) && $stable(dst_val))); // R9

endmodule

// File: rtl/qps_pc_unit.sv
module qps_pc_unit
    import qps_pkg::*;
#(
    parameter int ADDR_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  phase_t            phase,
    input  logic              jump_take,
    input  logic [ADDR_W-1:0] target,
    output logic [ADDR_W-1:0] pc,
    output logic [ADDR_W-1:0] ret_addr
);

    assign ret_addr = pc + 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc <= '0;
        end else if (phase == PH_WRITE) begin
            if (jump_take) pc <= target;
            else           pc <= ret_addr;
        end
    end

    AST_PC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != PH_WRITE) |=> $stable(pc)); // R8

    AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_WRITE && !jump_take) |=> (pc == ADDR_W'($past(pc) + 1'b1))); // R8

    AST_PC_JUMP: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_WRITE && jump_take) |=> (pc == $past(target))); // R7

endmodule

// File: rtl/quad_phase_seq.sv
module quad_phase_seq
    import qps_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [ADDR_W-1:0] ram_addr,
    input  logic [DATA_W-1:0] ram_rdata,
    output logic              ram_we,
    output logic [DATA_W-1:0] ram_wdata,
    input  logic [DATA_W-1:0] alu_result,
    input  logic              jump_take,
    output logic [OP_W-1:0]   op_code,
    output logic [DATA_W-1:0] src_val,
    output logic [DATA_W-1:0] dst_val,
    output logic [ADDR_W-1:0] pc
);

    localparam int PAD_W = DATA_W - ADDR_W;

    phase_t            phase;
    logic              wr_bit;
    logic [ADDR_W-1:0] src_idx;
    logic [ADDR_W-1:0] dst_idx;
    logic [ADDR_W-1:0] ret_addr;

    qps_phase_ctrl u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .phase (phase)
    );

    qps_operand_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_opnd (
        .clk       (clk),
        .rst_n     (rst_n),
        .phase     (phase),
        .ram_rdata (ram_rdata),
        .op        (op_code),
        .wr_bit    (wr_bit),
        .src_idx   (src_idx),
        .dst_idx   (dst_idx),
        .src_val   (src_val),
        .dst_val   (dst_val)
    );

    qps_pc_unit #(.ADDR_W(ADDR_W)) u_pc (
        .clk       (clk),
        .rst_n     (rst_n),
        .phase     (phase),
        .jump_take (jump_take),
        .target    (src_val[ADDR_W-1:0]),
        .pc        (pc),
        .ret_addr  (ret_addr)
    );

    // Single RAM port: one owner per slot
    always_comb begin
        ram_we    = 1'b0;
        ram_wdata = jump_take ? {{PAD_W{1'b0}}, ret_addr} : alu_result;
        unique case (phase)
            PH_FETCH: ram_addr = pc;
            PH_SRC:   ram_addr = src_idx;
            PH_DST:   ram_addr = dst_idx;
            PH_WRITE: begin
                ram_addr = dst_idx;
                ram_we   = wr_bit;
            end
            default:  ram_addr = pc;
        endcase
    end

    AST_WE_LAST_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> (phase == PH_WRITE)); // R4

    AST_WRITE_ADDR_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_WRITE) |-> (ram_addr == $past(ram_addr))); // R3

endmodule

// File: tb/quad_phase_seq_test.sv
module quad_phase_seq_test;

    localparam int DW = 32;
    localparam int AW = 9;
    localparam int OP_ADD = 0;
    localparam int OP_XOR = 1;
    localparam int OP_JMP = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] ram_addr;
    logic [DW-1:0] ram_rdata;
    logic          ram_we;
    logic [DW-1:0] ram_wdata;
    logic [DW-1:0] alu_result;
    logic          jump_take;
    logic [5:0]    op_code;
    logic [DW-1:0] src_val;
    logic [DW-1:0] dst_val;
    logic [AW-1:0] pc;

    logic [DW-1:0] mem [512];   // RAM seen by the design
    logic [DW-1:0] mm  [512];   // reference model's own copy

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done  = 0;

    always #2.5 clk = ~clk;

    function automatic logic [DW-1:0] fn(input int op, input logic [DW-1:0] s, input logic [DW-1:0] d);
        if (op == OP_ADD)      return d + s;
        else if (op == OP_XOR) return d ^ s;
        else                   return s;
    endfunction

    assign ram_rdata  = mem[ram_addr];
    assign alu_result = fn(int'(op_code), src_val, dst_val);
    assign jump_take  = (op_code == 6'(OP_JMP));

    quad_phase_seq #(.DATA_W(DW), .ADDR_W(AW)) uut (
        .clk(clk), .rst_n(rst_n), .ram_addr(ram_addr), .ram_rdata(ram_rdata),
        .ram_we(ram_we), .ram_wdata(ram_wdata), .alu_result(alu_result),
        .jump_take(jump_take), .op_code(op_code), .src_val(src_val),
        .dst_val(dst_val), .pc(pc)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s at %0t: actual %0h expected %0h", req, $time, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] mk(input int op, input bit we, input bit imm, input int d, input int s);
        return {op[5:0], we, imm, 6'b0, d[8:0], s[8:0]};
    endfunction

    // reference state
    int            m_ph;
    logic [AW-1:0] m_pc;
    logic [DW-1:0] m_ins, m_src, m_dst;

    task automatic model_reset();
        m_ph = 0; m_pc = '0; m_ins = '0; m_src = '0; m_dst = '0;
    endtask

    // compare outputs for the current cycle, then advance the model one clock
    task automatic step();
        int            op;
        logic [AW-1:0] sidx, didx;
        logic          wbit, ibit, jmp;
        logic [DW-1:0] wd;
        op   = int'(m_ins[31:26]);
        wbit = m_ins[25];
        ibit = m_ins[24];
        didx = m_ins[17:9];
        sidx = m_ins[8:0];
        jmp  = (op == OP_JMP);
        wd   = jmp ? {{(DW-AW){1'b0}}, AW'(m_pc + 1'b1)} : fn(op, m_src, m_dst);
        chk(pc == m_pc, "R8", pc, m_pc);
        case (m_ph)
            0: begin
                chk(ram_addr == m_pc, "R3", ram_addr, m_pc);
                chk(!ram_we, "R2", ram_we, 0);
                m_ins = mm[m_pc];
            end
            1: begin
                chk(ram_addr == sidx, "R3", ram_addr, sidx);
                chk(!ram_we, "R2", ram_we, 0);
                m_src = ibit ? {{(DW-AW){1'b0}}, sidx} : mm[sidx];
            end
            2: begin
                chk(ram_addr == didx, "R3", ram_addr, didx);
                chk(!ram_we, "R2", ram_we, 0);
                chk(src_val == m_src, "R5", src_val, m_src);
                m_dst = mm[didx];
            end
            default: begin
                chk(ram_addr == didx, "R3", ram_addr, didx);
                chk(ram_we == wbit, "R4", ram_we, wbit);
                chk(op_code == op[5:0], "R9", op_code, op);
                chk(dst_val == m_dst, "R9", dst_val, m_dst);
                if (wbit)
                    chk(ram_wdata == wd, jmp ? "R7" : "R6", ram_wdata, wd);
                if (wbit) mm[didx] = wd;
                m_pc = jmp ? m_src[AW-1:0] : AW'(m_pc + 1'b1);
            end
        endcase
        if (ram_we) mem[ram_addr] = ram_wdata;   // RAM write for this slot
        m_ph = (m_ph + 1) % 4;
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) begin
            #1 step();
            @(negedge clk);
        end
    endtask

    task automatic reset_check();
        chk(pc == '0, "R1", pc, 0);
        chk(ram_addr == '0, "R1", ram_addr, 0);
        chk(!ram_we, "R1", ram_we, 0);
    endtask

    initial begin
        for (int a = 0; a < 512; a++) mem[a] = 32'(a * 3 + 1);
        mem[0]   = mk(OP_ADD, 1, 0, 100, 101);
        mem[1]   = mk(OP_XOR, 1, 1, 100, 9'h1F);   // immediate
        mem[2]   = mk(OP_ADD, 0, 0, 102, 101);     // write suppressed
        mem[3]   = mk(OP_JMP, 1, 0, 103, 104);     // jump-and-link through r104
        mem[4]   = mk(OP_ADD, 1, 0, 110, 110);     // skipped
        mem[5]   = mk(OP_ADD, 1, 0, 110, 110);     // skipped
        mem[6]   = mk(OP_JMP, 0, 1, 0, 9);         // immediate jump, no link
        mem[9]   = mk(OP_ADD, 1, 0, 105, 100);
        mem[10]  = mk(OP_JMP, 1, 1, 106, 511);     // link into r106, go to top
        mem[511] = mk(OP_XOR, 1, 0, 107, 100);     // then pc wraps to 0
        mem[100] = 32'd5;
        mem[101] = 32'd7;
        mem[102] = 32'h55;
        mem[104] = 32'd6;
        mem[105] = 32'd3;
        mem[110] = 32'hCAFE;
        for (int a = 0; a < 512; a++) mm[a] = mem[a];
        model_reset();

        repeat (3) @(negedge clk);
        #1 reset_check();                          // R1 held in reset
        @(negedge clk);
        rst_n = 1'b1;
        #0.5 reset_check();                        // R1 first cycle after release
        @(negedge clk);
        // first cycle already compared by the model as well
        model_reset();
        m_ph = 1; m_ins = mm[0];
        run(400);

        // directed end-of-run checks at the RAM port
        chk(mem[102] == 32'h55, "R4", mem[102], 32'h55);
        chk(mem[110] == 32'hCAFE, "R7", mem[110], 32'hCAFE);
        chk(mem[103] == 32'd4, "R7", mem[103], 4);
        chk(mem[106] == 32'd11, "R7", mem[106], 11);

        // reset in the middle of an instruction
        repeat (2) @(negedge clk);
        m_ph = (m_ph + 2) % 4;
        rst_n = 1'b0;
        #1 reset_check();
        @(negedge clk);
        rst_n = 1'b1;
        model_reset();
        run(120);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL R2 watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule